// File: doc/BRIEF.md
# ATA Multiword DMA Burst Sequencer

This block paces a multiword DMA burst on an ATA data port. A start pulse sets the busy flag, which also withdraws permission to drive the task-file chip selects. The block then waits for the drive's DMA request and opens the burst by asserting the DMA acknowledge. After that it issues one read or write strobe per data word. Each phase of a word cycle is timed by its own down counter, and each counter is loaded from a configuration input when the previous phase ends.

A read strobe ends by capturing the data bus and pushing the word into the receive FIFO. A write strobe starts by popping a word from the transmit FIFO and driving it on the bus. If the FIFO cannot take or supply a word, the strobe is held back. At the end of each cycle the drive request is sampled. If it is still high, another cycle follows. If it is low, two termination counters start: one ends the acknowledge and the other clears the busy flag. Software loads the counter values. The block only reports whether the cycle time leaves room for the strobe and recovery phases.

Top module: `ata_mdma_seq`

## Requirements
- R1: While reset is asserted and right after it, dmack, dior, diow, busy, rd_push, wr_pop and cfg_err are 0 and cs_en is 1.
- R2: A start pulse sampled while idle sets busy and clears cs_en at that same clock edge. A start pulse sampled while busy is ignored, so busy stays 0 once the burst has finished.
- R3: With the sequencer armed, the edge that samples dmarq high loads the setup counter (value M). dmack rises M edges later and the first strobe one edge after that. No strobe is ever asserted without dmack.
- R4: A strobe stays high for exactly the strobe-width value of edges. In read mode, the edge that ends it also raises rd_push for one cycle, with rd_data equal to the dd_in value sampled at that edge.
- R5: While dmarq stays high, consecutive strobes start every T0+1 edges. A new strobe waits until the recovery counter TK has expired after the previous strobe ended.
- R6: In write mode, wr_pop is high in the cycle just before a strobe starts. From that strobe on, dd_out holds the popped wr_data, and dd_oe equals dmack.
- R7: At the edge where T0 expires, a dmarq that is low starts both termination counters. dmack falls TJ edges later and busy falls TN edges later; each is independent of the other.
- R8: cfg_err follows the current configuration one edge later. It is 1 when cfg_t0 is less than or equal to cfg_td plus cfg_tk, and 0 otherwise.
- R9: A strobe that is due while rd_fifo_full (read) or wr_fifo_empty (write) is high is held off. dmack stays asserted, no pop occurs, and the strobe starts on the edge after the condition clears.
- R10: dir_write (1 = write on diow, 0 = read on dior) is sampled only by an accepted start; changes while busy have no effect.
- R11: In write mode the next strobe also waits for the hold counter TH, which is loaded when a strobe ends. The write period is therefore max(T0, TD+TH)+1 edges. In read mode TH has no effect on timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Burst start pulse |
| dir_write | input | 1 | 1 = write burst, 0 = read burst |
| dmarq | input | 1 | Drive DMA request |
| cfg_tm | input | 8 | Setup count before acknowledge |
| cfg_td | input | 8 | Strobe width count |
| cfg_tk | input | 8 | Strobe recovery count |
| cfg_th | input | 8 | Write data hold count |
| cfg_t0 | input | 8 | Cycle time count |
| cfg_tj | input | 8 | Acknowledge release count |
| cfg_tn | input | 8 | Busy release count |
| dd_in | input | 16 | Data bus from drive |
| dd_out | output | 16 | Data bus toward drive |
| dd_oe | output | 1 | Data bus output enable |
| dior | output | 1 | Read strobe |
| diow | output | 1 | Write strobe |
| dmack | output | 1 | DMA acknowledge |
| cs_en | output | 1 | Chip selects may be driven |
| busy | output | 1 | DMA in progress |
| cfg_err | output | 1 | Cycle time too short |
| rd_fifo_full | input | 1 | Receive FIFO full |
| rd_push | output | 1 | Receive FIFO push |
| rd_data | output | 16 | Receive FIFO data |
| wr_fifo_empty | input | 1 | Transmit FIFO empty |
| wr_pop | output | 1 | Transmit FIFO pop |
| wr_data | input | 16 | Transmit FIFO data |

## Verification
Every output is registered, so each result is due a fixed number of edges after its cause. dmack rises M edges after dmarq is sampled, and the strobe follows one edge later. A strobe falls TD edges after it rises, with rd_push on that same edge. Strobes repeat at the period from R5 or R11. dmack and busy fall TJ and TN edges after the T0 expiry. The bench counts edges from the start pulse and samples at each falling clock edge. It compares the recorded edge index of every transition with these formulas, and compares data words against patterns that change once per strobe.

// File: rtl/ata_mdma_pkg.sv
package ata_mdma_pkg;
    localparam int NCNT   = 7;
    localparam int CI_TM  = 0;
    localparam int CI_TD  = 1;
    localparam int CI_TK  = 2;
    localparam int CI_TH  = 3;
    localparam int CI_T0  = 4;
    localparam int CI_TJ  = 5;
    localparam int CI_TN  = 6;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ARM,
        S_SETUP,
        S_LAUNCH,
        S_STROBE,
        S_RECOVER,
        S_TERM
    } seq_state_t;
endpackage

// File: rtl/mdma_down_cnt.sv
module mdma_down_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         expire
);
    logic [W-1:0] cnt_d, cnt_q;
    logic         run_d, run_q;

    assign expire = run_q && (cnt_q <= W'(1));

    always_comb begin
        cnt_d = cnt_q;
        run_d = run_q;
        if (load) begin
            cnt_d = val;
            run_d = 1'b1;
        end else if (run_q) begin
            if (expire) run_d = 1'b0;
            else        cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            run_q <= run_d;
        end
    end
endmodule

// File: rtl/mdma_cycle_rule.sv
module mdma_cycle_rule #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] t0,
    input  logic [W-1:0] td,
    input  logic [W-1:0] tk,
    output logic         err
);
    localparam int SW = W + 1;
    logic err_d, err_q;

    always_comb begin
        err_d = ({1'b0, t0} <= ({1'b0, td} + {1'b0, tk}));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_d;
    end

    assign err = err_q;

    logic [SW-1:0] unused_w;
    assign unused_w = '0;
endmodule

// File: rtl/ata_mdma_seq.sv
module ata_mdma_seq
    import ata_mdma_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir_write,
    input  logic              dmarq,
    input  logic [CNT_W-1:0]  cfg_tm,
    input  logic [CNT_W-1:0]  cfg_td,
    input  logic [CNT_W-1:0]  cfg_tk,
    input  logic [CNT_W-1:0]  cfg_th,
    input  logic [CNT_W-1:0]  cfg_t0,
    input  logic [CNT_W-1:0]  cfg_tj,
    input  logic [CNT_W-1:0]  cfg_tn,
    input  logic [DATA_W-1:0] dd_in,
    output logic [DATA_W-1:0] dd_out,
    output logic              dd_oe,
    output logic              dior,
    output logic              diow,
    output logic              dmack,
    output logic              cs_en,
    output logic              busy,
    output logic              cfg_err,
    input  logic              rd_fifo_full,
    output logic              rd_push,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_fifo_empty,
    output logic              wr_pop,
    input  logic [DATA_W-1:0] wr_data
);
    typedef struct packed {
        seq_state_t        state;
        logic              busy;
        logic              dir;
        logic              dmack;
        logic              strobe;
        logic              tk_done;
        logic              th_done;
        logic              rd_push;
        logic [DATA_W-1:0] rd_data;
        logic [DATA_W-1:0] dd_out;
    } seq_t;

    seq_t             st_d, st_q;
    logic [NCNT-1:0]  ld, ex;
    logic [CNT_W-1:0] cfg_v [NCNT];
    logic             pop_d;
    logic             can_go;
    logic             dir_sel;

    assign cfg_v[CI_TM] = cfg_tm;
    assign cfg_v[CI_TD] = cfg_td;
    assign cfg_v[CI_TK] = cfg_tk;
    assign cfg_v[CI_TH] = cfg_th;
    assign cfg_v[CI_T0] = cfg_t0;
    assign cfg_v[CI_TJ] = cfg_tj;
    assign cfg_v[CI_TN] = cfg_tn;

    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        mdma_down_cnt #(.W(CNT_W)) cnt_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (ld[g]),
            .val    (cfg_v[g]),
            .expire (ex[g])
        );
    end

    mdma_cycle_rule #(.W(CNT_W)) rule_i (
        .clk   (clk),
        .rst_n (rst_n),
        .t0    (cfg_t0),
        .td    (cfg_td),
        .tk    (cfg_tk),
        .err   (cfg_err)
    );

    // a strobe may start once recovery is over and the FIFO can move a word
    assign can_go = st_q.tk_done &&
                    (st_q.dir ? (st_q.th_done && !wr_fifo_empty) : !rd_fifo_full);

    always_comb begin
        st_d         = st_q;
        st_d.rd_push = 1'b0;
        ld           = '0;
        pop_d        = 1'b0;
        if (ex[CI_TK]) st_d.tk_done = 1'b1;
        if (ex[CI_TH]) st_d.th_done = 1'b1;
        unique case (st_q.state)
            S_IDLE: begin
                if (start) begin
                    st_d.busy    = 1'b1;
                    st_d.dir     = dir_write;
                    st_d.tk_done = 1'b1;
                    st_d.th_done = 1'b1;
                    st_d.state   = S_ARM;
                end
            end
            S_ARM: begin
                if (dmarq) begin
                    ld[CI_TM]  = 1'b1;
                    st_d.state = S_SETUP;
                end
            end
            S_SETUP: begin
                if (ex[CI_TM]) begin
                    st_d.dmack = 1'b1;
                    st_d.state = S_LAUNCH;
                end
            end
            S_LAUNCH: begin
                if (can_go) begin
                    st_d.strobe = 1'b1;
                    ld[CI_TD]   = 1'b1;
                    ld[CI_T0]   = 1'b1;
                    if (st_q.dir) begin
                        pop_d       = 1'b1;
                        st_d.dd_out = wr_data;
                    end
                    st_d.state = S_STROBE;
                end
            end
            S_STROBE: begin
                if (ex[CI_TD]) begin
                    st_d.strobe  = 1'b0;
                    ld[CI_TK]    = 1'b1;
                    ld[CI_TH]    = 1'b1;
                    st_d.tk_done = 1'b0;
                    st_d.th_done = 1'b0;
                    if (!st_q.dir) begin
                        st_d.rd_push = 1'b1;
                        st_d.rd_data = dd_in;
                    end
                    st_d.state = S_RECOVER;
                end
            end
            S_RECOVER: begin
                if (ex[CI_T0]) begin
                    if (dmarq) begin
                        st_d.state = S_LAUNCH;
                    end else begin
                        ld[CI_TJ]  = 1'b1;
                        ld[CI_TN]  = 1'b1;
                        st_d.state = S_TERM;
                    end
                end
            end
            S_TERM: begin
                if (ex[CI_TJ]) st_d.dmack = 1'b0;
                if (ex[CI_TN]) st_d.busy  = 1'b0;
                if (!st_d.dmack && !st_d.busy) st_d.state = S_IDLE;
            end
            default: st_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= S_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign dir_sel = st_q.dir;
    assign dior    = st_q.strobe && !st_q.dir;
    assign diow    = st_q.strobe && st_q.dir;
    assign dmack   = st_q.dmack;
    assign busy    = st_q.busy;
    assign cs_en   = !st_q.busy;
    assign dd_oe   = st_q.dmack && st_q.dir;
    assign dd_out  = st_q.dd_out;
    assign rd_push = st_q.rd_push;
    assign rd_data = st_q.rd_data;
    assign wr_pop  = pop_d;
endmodule

// File: rtl/ata_mdma_seq_chk.sv
module ata_mdma_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic dior,
    input logic diow,
    input logic dmack,
    input logic busy,
    input logic rd_push,
    input logic wr_pop,
    input logic rd_fifo_full,
    input logic wr_fifo_empty,
    input logic dir_sel
);
    p_single_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(dior && diow));

    p_strobe_has_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dior || diow) |-> dmack);

    p_push_ends_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_push |-> ($past(dior) && !dior));

    p_pop_opens_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pop |=> diow);

    p_dir_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(dir_sel));

    p_read_waits_room_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dior) |-> !$past(rd_fifo_full));

    p_write_waits_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(diow) |-> !$past(wr_fifo_empty));

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !dmack) |-> !(dior || diow));
endmodule

bind ata_mdma_seq ata_mdma_seq_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .dior          (dior),
    .diow          (diow),
    .dmack         (dmack),
    .busy          (busy),
    .rd_push       (rd_push),
    .wr_pop        (wr_pop),
    .rd_fifo_full  (rd_fifo_full),
    .wr_fifo_empty (wr_fifo_empty),
    .dir_sel       (dir_sel)
);

// File: tb/ata_mdma_seq_tb_top.sv
module ata_mdma_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, dir_write = 1'b0, dmarq = 1'b0;
    logic [7:0]  cfg_tm = 8'd2, cfg_td = 8'd2, cfg_tk = 8'd1, cfg_th = 8'd1;
    logic [7:0]  cfg_t0 = 8'd5, cfg_tj = 8'd2, cfg_tn = 8'd2;
    logic [15:0] dd_in = '0, wr_data = '0;
    logic        rd_fifo_full = 1'b0, wr_fifo_empty = 1'b0;
    logic [15:0] dd_out, rd_data;
    logic        dd_oe, dior, diow, dmack, cs_en, busy, cfg_err, rd_push, wr_pop;

    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    ata_mdma_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_write(dir_write), .dmarq(dmarq),
        .cfg_tm(cfg_tm), .cfg_td(cfg_td), .cfg_tk(cfg_tk), .cfg_th(cfg_th),
        .cfg_t0(cfg_t0), .cfg_tj(cfg_tj), .cfg_tn(cfg_tn),
        .dd_in(dd_in), .dd_out(dd_out), .dd_oe(dd_oe), .dior(dior), .diow(diow),
        .dmack(dmack), .cs_en(cs_en), .busy(busy), .cfg_err(cfg_err),
        .rd_fifo_full(rd_fifo_full), .rd_push(rd_push), .rd_data(rd_data),
        .wr_fifo_empty(wr_fifo_empty), .wr_pop(wr_pop), .wr_data(wr_data)
    );

    typedef struct packed {
        logic       dir;
        logic [7:0] tm, td, tk, th, t0, tj, tn;
        logic [3:0] n;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'd3, 8'd4, 8'd2, 8'd1, 8'd8, 8'd2, 8'd4, 4'd3},
        '{1'b1, 8'd2, 8'd3, 8'd2, 8'd2, 8'd7, 8'd4, 8'd2, 4'd4},
        '{1'b1, 8'd1, 8'd2, 8'd1, 8'd9, 8'd5, 8'd1, 8'd1, 4'd3},
        '{1'b0, 8'd5, 8'd1, 8'd1, 8'd9, 8'd3, 8'd3, 8'd3, 4'd2},
        '{1'b0, 8'd1, 8'd2, 8'd1, 8'd1, 8'd4, 8'd1, 8'd6, 4'd1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v);
        int k = 0, nr = 0, last = 0, pops = 0, pushes = 0, per, kd = -1, kb = -1;
        bit pd = 1'b0, ps = 1'b0, pb = 1'b1, pend = 1'b0, s;
        per = (v.dir && (int'(v.td) + int'(v.th) > int'(v.t0))) ?
              int'(v.td) + int'(v.th) + 1 : int'(v.t0) + 1;
        @(negedge clk);
        cfg_tm = v.tm; cfg_td = v.td; cfg_tk = v.tk; cfg_th = v.th;
        cfg_t0 = v.t0; cfg_tj = v.tj; cfg_tn = v.tn;
        dir_write = v.dir; dmarq = 1'b1; wr_data = 16'h5000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        dir_write = !v.dir;                      // R10: change ignored while busy
        chk(busy && !cs_en, "R2 busy set by start", busy, 1);
        for (int it = 0; it < 3000 && (kd < 0 || kb < 0); it++) begin
            @(negedge clk);
            k++;
            start = 1'b0;
            if (pend) begin
                pops++;
                wr_data = 16'h5000 + 16'(pops);
                pend = 1'b0;
            end
            s = dior | diow;
            if (dmack && !pd && nr == 0)
                chk(k == 1 + int'(v.tm), "R3 dmack edge", k, 1 + int'(v.tm));
            if (s && !ps) begin
                if (nr == 0) chk(k == 2 + int'(v.tm), "R3 first strobe edge", k, 2 + int'(v.tm));
                else         chk(k - last == per, "R5 R11 strobe period", k - last, per);
                chk(v.dir ? (diow && !dior) : (dior && !diow), "R10 strobe line", {30'd0, diow, dior},
                    v.dir ? 2 : 1);
                if (v.dir)
                    chk(dd_out == 16'h5000 + 16'(nr) && dd_oe, "R6 write word", int'(dd_out),
                        32'h5000 + nr);
                last = k;
                dd_in = 16'hA000 + 16'(nr);
                nr++;
                if (nr == 1) start = 1'b1;       // R2: start while busy
                if (nr == int'(v.n)) dmarq = 1'b0;
            end
            if (!s && ps) begin
                chk(k - last == int'(v.td), "R4 strobe width", k - last, int'(v.td));
                if (!v.dir)
                    chk(rd_push && rd_data == 16'hA000 + 16'(nr - 1), "R4 read capture",
                        int'(rd_data), 32'hA000 + nr - 1);
            end
            if (rd_push) pushes++;
            if (wr_pop) pend = 1'b1;
            if (!dmack && pd && kd < 0) kd = k;
            if (!busy && pb && kb < 0) kb = k;
            pd = dmack; ps = s; pb = busy;
        end
        chk(kd == last + int'(v.t0) + int'(v.tj), "R7 dmack release", kd, last + int'(v.t0) + int'(v.tj));
        chk(kb == last + int'(v.t0) + int'(v.tn), "R7 busy release", kb, last + int'(v.t0) + int'(v.tn));
        chk(nr == int'(v.n), "R5 word count", nr, int'(v.n));
        if (v.dir) chk(pops == int'(v.n), "R6 pop count", pops, int'(v.n));
        else       chk(pushes == int'(v.n), "R4 push count", pushes, int'(v.n));
        repeat (4) @(negedge clk);
        chk(!busy && !dmack && cs_en, "R2 start during burst ignored", busy, 0);
    endtask

    task automatic run_defer(input bit wr);
        @(negedge clk);
        cfg_tm = 8'd2; cfg_td = 8'd2; cfg_tk = 8'd1; cfg_th = 8'd1;
        cfg_t0 = 8'd5; cfg_tj = 8'd2; cfg_tn = 8'd2;
        dmarq = 1'b0; dir_write = wr; wr_data = 16'h7777;
        rd_fifo_full = !wr; wr_fifo_empty = wr; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        chk(busy && !cs_en && !dmack, "R3 armed waits for request", dmack, 0);
        dmarq = 1'b1;
        repeat (2) @(negedge clk);
        chk(!dmack, "R3 setup still running", dmack, 0);
        @(negedge clk);
        chk(dmack, "R3 dmack after setup", dmack, 1);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(dmack && !dior && !diow && !wr_pop, "R9 strobe held off", {30'd0, diow, dior}, 0);
        end
        rd_fifo_full = 1'b0; wr_fifo_empty = 1'b0;
        @(negedge clk);
        chk(wr ? diow : dior, "R9 strobe after release", {30'd0, diow, dior}, wr ? 2 : 1);
        if (wr) chk(dd_out == 16'h7777, "R6 write word after release", int'(dd_out), 32'h7777);
        dmarq = 1'b0;
        for (int i = 0; i < 100 && (busy || dmack); i++) @(negedge clk);
        chk(!busy && !dmack, "R7 terminated after deferral", busy, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!dmack && !dior && !diow && !busy && cs_en && !rd_push && !wr_pop && !cfg_err,
            "R1 reset state", {29'd0, dmack, busy, cfg_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!dmack && !dior && !diow && !busy && cs_en, "R1 after reset", busy, 0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        run_defer(1'b0);
        run_defer(1'b1);

        @(negedge clk);
        cfg_td = 8'd4; cfg_tk = 8'd2; cfg_t0 = 8'd6;
        @(negedge clk);
        chk(cfg_err, "R8 cycle equal to sum flagged", cfg_err, 1);
        cfg_t0 = 8'd7;
        @(negedge clk);
        chk(!cfg_err, "R8 cycle above sum accepted", cfg_err, 0);
        cfg_t0 = 8'd3;
        @(negedge clk);
        chk(cfg_err, "R8 cycle below sum flagged", cfg_err, 1);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule